// File: doc/BRIEF.md
# Bit-Serial Memory Address Sequencer

This block is the control front end of a 1600-bit memory that is read and written one bit at a time. An external host drives a slow serial clock line, a reset line and a data-in line. The block samples these lines on the fast system clock and turns their edges into one-cycle events. A falling edge of the serial clock moves the bit address forward. A falling edge of the reset line, seen while the serial clock is low, sends the address back to zero.

From the current address the block decodes which named zone is being touched. It also decides whether the bit read from the array may be driven back on the data line. The line is released ahead of, and across, the secret-code and erase-key fields so that these fields never leak.

Inside those fields the block latches each presented bit on a serial-clock fall. It reports whether that bit matched the stored bit one fall later. It also keeps three per-zone erase flags, which an address reset clears.

Top module: `serial_addr_seq`

## Requirements
- R1: The address counts 0,1,...,1599; a serial-clock fall at address 1599 gives address 0, and the address never leaves 0..1599.
- R2: A falling edge on `card_clk_i` advances the address by one, visible on `addr_o` one system-clock cycle later; a high or a rising serial clock leaves the address unchanged.
- R3: A falling edge on `card_rst_i` while `card_clk_i` is low forces the address to 0 one cycle later; the same edge while `card_clk_i` is high is ignored.
- R4: When an address reset and a serial-clock fall occur in the same system cycle, the reset wins and the address becomes 0.
- R5: `zone_o` decodes the address as 0 fabrication 0–15, 1 issuer 16–79, 2 secret code 80–95, 3 attempt counter 96–111, 4 protected 112–175, 5 app1 176–431, 6 key1 432–479, 7 app2 480–735, 8 key2 736–767, 9 aux 768–1023, 10 app3 1024–1535, 11 key3 1536–1583, 12 tail 1584–1599.
- R6: While `dout_oe_o` is 1, `dout_o` equals `mem_bit_i`, which is the stored bit at `addr_o`, and after an address reset this is the bit at address 0. While `dout_oe_o` is 0, `dout_o` is 0.
- R7: `dout_oe_o` is 0 at every address in zones 2, 6, 8 and 11. It falls one cycle after a serial-clock rise at the address just before such a zone. It is 1 at every other address once the serial clock is low.
- R8: On a serial-clock fall at an address in zones 2, 6, 8 or 11, `din_i` and the stored bit are latched. On the next fall, `cmp_valid_o` pulses high for one cycle with `cmp_match_o` = 1 if the two were equal and 0 otherwise. An address reset drops any pending comparison.
- R9: Bit k of `er_set_i` sets bit k of `er_flags_o` one cycle later, and the flags hold across address steps. An address reset clears all three flags, and the reset wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| card_clk_i | input | 1 | Serial clock line, already synchronous to `clk` |
| card_rst_i | input | 1 | Serial reset line, already synchronous to `clk` |
| din_i | input | 1 | Serial data in |
| mem_bit_i | input | 1 | Stored bit read from the array at `addr_o` |
| er_set_i | input | 3 | Per-zone erase flag set strobes |
| addr_o | output | 11 | Current bit address |
| zone_o | output | 4 | Zone code of the current address |
| dout_o | output | 1 | Data out value |
| dout_oe_o | output | 1 | Data out enable (0 = line floats) |
| cmp_valid_o | output | 1 | One-cycle compare result strobe |
| cmp_match_o | output | 1 | Compare result, valid with `cmp_valid_o` |
| er_flags_o | output | 3 | Zone erase flags |

## Verification
An address reset and an address step can land in the same system cycle. The bench provokes this by holding both lines high and dropping them together on one cycle. It judges the result as address 0, erase flags cleared and no compare strobe, which shows that the reset took priority over the step. A second overlap is an erase-flag set arriving in the very cycle of an address reset. There the cleared flags show that the clear took priority over the set.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int MEM_BITS = 1600;
  localparam int ADDR_W   = $clog2(MEM_BITS);
  localparam int ZONE_N   = 13;
  localparam int ZONE_W   = $clog2(ZONE_N);
  localparam int ER_N     = 3;

  typedef enum logic [ZONE_W-1:0] {
    Z_FAB, Z_ISS, Z_SEC, Z_ATT, Z_CPZ, Z_APP1, Z_KEY1,
    Z_APP2, Z_KEY2, Z_AUX, Z_APP3, Z_KEY3, Z_TAIL
  } zone_e;

  // first address of each zone, ascending
  localparam int ZSTART [ZONE_N] = '{0, 16, 80, 96, 112, 176, 432,
                                     480, 736, 768, 1024, 1536, 1584};

  function automatic zone_e zone_of(input logic [ADDR_W-1:0] a);
    zone_e z;
    z = Z_FAB;
    for (int i = 0; i < ZONE_N; i++)
      if (int'(a) >= ZSTART[i]) z = zone_e'(ZONE_W'(i));
    return z;
  endfunction

  function automatic logic is_secret(input logic [ADDR_W-1:0] a);
    zone_e z;
    z = zone_of(a);
    return (z == Z_SEC) || (z == Z_KEY1) || (z == Z_KEY2) || (z == Z_KEY3);
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (int'(a) == MEM_BITS - 1) ? '0 : a + 1'b1;
  endfunction
endpackage

// File: rtl/seq_edge_det.sv
module seq_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl_i[g];
    assign rise_o[g] =  lvl_i[g] & ~lvl_q[g];
    assign fall_o[g] = ~lvl_i[g] &  lvl_q[g];
  end
endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MEM_BITS - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      addr_o <= '0;
    else if (clr_i)  addr_o <= '0;
    else if (step_i) addr_o <= step_addr(addr_o);

  assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_o <= LAST);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && addr_o == LAST) |=> addr_o == '0);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && addr_o != LAST) |=> addr_o == $past(addr_o) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(addr_o));
  assert_reset_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> addr_o == '0);
endmodule

// File: rtl/seq_zone_dec.sv
module seq_zone_dec
  import seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ZONE_W-1:0] zone_o,
  output logic              secret_o
);
  always_comb begin
    zone_o   = zone_of(addr_i);
    secret_o = is_secret(addr_i);
  end
endmodule

// File: rtl/seq_io_ctl.sv
module seq_io_ctl
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              secret_i,
  input  logic              step_i,
  input  logic              rise_i,
  input  logic              clr_i,
  input  logic              din_i,
  input  logic              mem_bit_i,
  input  logic [ER_N-1:0]   er_set_i,
  output logic              oe_o,
  output logic              dout_o,
  output logic              cmp_valid_o,
  output logic              cmp_match_o,
  output logic [ER_N-1:0]   er_flags_o
);
  logic next_secret;
  logic cmp_pend, cmp_din, cmp_ref;

  assign next_secret = is_secret(step_addr(addr_i));

  // output enable: dropped early on the rise before a secret field
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      oe_o <= 1'b1;
    else if (clr_i)  oe_o <= ~is_secret('0);
    else if (step_i) oe_o <= ~next_secret;
    else if (rise_i && next_secret) oe_o <= 1'b0;

  assign dout_o = oe_o & mem_bit_i;

  // compare pipeline: latch on one fall, judge on the next
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_pend <= 1'b0; cmp_din <= 1'b0; cmp_ref <= 1'b0;
      cmp_valid_o <= 1'b0; cmp_match_o <= 1'b0;
    end else if (clr_i) begin
      cmp_pend <= 1'b0; cmp_valid_o <= 1'b0;
    end else if (step_i) begin
      cmp_valid_o <= cmp_pend;
      if (cmp_pend) cmp_match_o <= (cmp_din == cmp_ref);
      cmp_pend <= secret_i;
      cmp_din  <= din_i;
      cmp_ref  <= mem_bit_i;
    end else begin
      cmp_valid_o <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     er_flags_o <= '0;
    else if (clr_i) er_flags_o <= '0;
    else            er_flags_o <= er_flags_o | er_set_i;

  assert_oe_secret_R7: assert property (@(posedge clk) disable iff (!rst_n)
    secret_i |-> !oe_o);
  assert_oe_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !clr_i && next_secret) |=> !oe_o);
  assert_dout_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> !dout_o);
  assert_cmp_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid_o |-> $past(step_i) && !$past(clr_i));
  assert_cmp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_o && !step_i) |=> !cmp_valid_o);
  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> er_flags_o == '0);
  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (er_flags_o & $past(er_flags_o)) == $past(er_flags_o));
endmodule

// File: rtl/serial_addr_seq.sv
module serial_addr_seq
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_clk_i,
  input  logic              card_rst_i,
  input  logic              din_i,
  input  logic              mem_bit_i,
  input  logic [ER_N-1:0]   er_set_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ZONE_W-1:0] zone_o,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              cmp_valid_o,
  output logic              cmp_match_o,
  output logic [ER_N-1:0]   er_flags_o
);
  logic [1:0] rise, fall;
  logic       step_ev, rise_ev, clr_ev, secret;

  seq_edge_det #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i({card_rst_i, card_clk_i}),
    .rise_o(rise), .fall_o(fall)
  );

  // named events
  assign step_ev = fall[0];
  assign rise_ev = rise[0];
  assign clr_ev  = fall[1] & ~card_clk_i;

  seq_addr_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .step_i(step_ev), .clr_i(clr_ev), .addr_o(addr_o)
  );

  seq_zone_dec u_zone (.addr_i(addr_o), .zone_o(zone_o), .secret_o(secret));

  seq_io_ctl u_io (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_o), .secret_i(secret),
    .step_i(step_ev), .rise_i(rise_ev), .clr_i(clr_ev), .din_i(din_i),
    .mem_bit_i(mem_bit_i), .er_set_i(er_set_i), .oe_o(dout_oe_o),
    .dout_o(dout_o), .cmp_valid_o(cmp_valid_o), .cmp_match_o(cmp_match_o),
    .er_flags_o(er_flags_o)
  );

  assert_reset_needs_low_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[1] && card_clk_i && !step_ev && addr_o != '0) |=> addr_o != '0);
endmodule

// File: tb/sim_serial_addr_seq.sv
`timescale 1ns/1ps
module sim_serial_addr_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic card_clk_i = 1'b0, card_rst_i = 1'b0, din_i = 1'b0;
  logic [2:0] er_set_i = '0;
  logic mem_bit_i;
  logic [10:0] addr_o;
  logic [3:0] zone_o;
  logic dout_o, dout_oe_o, cmp_valid_o, cmp_match_o;
  logic [2:0] er_flags_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  function automatic logic mbit(input int a);
    return a[0] ^ a[2] ^ a[5];
  endfunction

  assign mem_bit_i = mbit(int'(addr_o));

  serial_addr_seq u0 (.*);

  function automatic int exp_zone(input int a);
    if (a >= 1584) return 12; else if (a >= 1536) return 11;
    else if (a >= 1024) return 10; else if (a >= 768) return 9;
    else if (a >= 736) return 8; else if (a >= 480) return 7;
    else if (a >= 432) return 6; else if (a >= 176) return 5;
    else if (a >= 112) return 4; else if (a >= 96) return 3;
    else if (a >= 80) return 2; else if (a >= 16) return 1;
    return 0;
  endfunction

  function automatic logic exp_hidden(input int a);
    int z = exp_zone(a);
    return z == 2 || z == 6 || z == 8 || z == 11;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic d);
    card_clk_i = 1'b1; @(negedge clk);
    din_i = d; card_clk_i = 1'b0; @(negedge clk);
  endtask

  task automatic areset();
    card_rst_i = 1'b1; @(negedge clk);
    card_rst_i = 1'b0; @(negedge clk);
  endtask

  task automatic goto(input int a);
    areset();
    for (int i = 0; i < a; i++) step(1'b0);
  endtask

  task automatic t_reset_state();
    check("R5 zone at reset", zone_o, 0);
    check("R6 addr at reset", addr_o, 0);
    check("R6 dout after reset", dout_o, mbit(0));
    check("R7 oe at reset", dout_oe_o, 1);
    check("R9 flags at reset", er_flags_o, 0);
  endtask

  task automatic t_step();
    goto(0);
    for (int i = 1; i <= 5; i++) step(1'b0);
    check("R2 five steps", addr_o, 5);
    card_clk_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 high clock holds", addr_o, 5);
    card_clk_i = 1'b0; @(negedge clk);
    check("R2 fall advances", addr_o, 6);
  endtask

  task automatic t_sweep();
    int zbad = 0, obad = 0, dbad = 0;
    goto(0);
    for (int a = 0; a < 1600; a++) begin
      if (zone_o != 4'(exp_zone(a))) zbad++;
      if (dout_oe_o != !exp_hidden(a)) obad++;
      if (dout_o != (!exp_hidden(a) & mbit(a))) dbad++;
      if (a == 1599) check("R1 reach last", addr_o, 1599);
      if (a < 1599) step(1'b0);
    end
    check("R5 zone sweep mismatches", zbad, 0);
    check("R7 oe sweep mismatches", obad, 0);
    check("R6 dout sweep mismatches", dbad, 0);
    step(1'b0);
    check("R1 wrap to zero", addr_o, 0);
  endtask

  task automatic t_pre_field();
    goto(79);
    card_clk_i = 1'b1; @(negedge clk);
    check("R7 oe drops on rise before secret", dout_oe_o, 0);
    card_clk_i = 1'b0; @(negedge clk);
    check("R7 oe low in secret", dout_oe_o, 0);
    goto(78);
    card_clk_i = 1'b1; @(negedge clk);
    check("R7 oe kept two before secret", dout_oe_o, 1);
    card_clk_i = 1'b0; @(negedge clk);
    goto(431);
    card_clk_i = 1'b1; @(negedge clk);
    check("R7 oe drops before key1", dout_oe_o, 0);
    card_clk_i = 1'b0; @(negedge clk);
    goto(95);
    step(1'b0);
    check("R7 oe back after secret", dout_oe_o, 1);
  endtask

  task automatic t_reset_clk_high();
    goto(10);
    card_clk_i = 1'b1; @(negedge clk);
    card_rst_i = 1'b1; @(negedge clk);
    card_rst_i = 1'b0; @(negedge clk);
    check("R3 reset ignored clock high", addr_o, 10);
    card_clk_i = 1'b0; @(negedge clk);
    check("R3 step after ignored reset", addr_o, 11);
    areset();
    check("R3 reset with clock low", addr_o, 0);
  endtask

  task automatic t_coincide();
    goto(20);
    er_set_i = 3'b011; @(negedge clk); er_set_i = '0;
    card_clk_i = 1'b1; card_rst_i = 1'b1; @(negedge clk);
    card_clk_i = 1'b0; card_rst_i = 1'b0; @(negedge clk);
    check("R4 reset beats step", addr_o, 0);
    check("R4 flags cleared on coincide", er_flags_o, 0);
    check("R4 no compare strobe", cmp_valid_o, 0);
  endtask

  task automatic t_compare();
    goto(80);
    step(mbit(80));
    check("R8 no result before second fall", cmp_valid_o, 0);
    step(!mbit(81));
    check("R8 valid after match", cmp_valid_o, 1);
    check("R8 match result", cmp_match_o, 1);
    @(negedge clk);
    check("R8 valid one cycle", cmp_valid_o, 0);
    step(mbit(82));
    check("R8 mismatch result", cmp_match_o, 0);
    check("R8 valid after mismatch", cmp_valid_o, 1);
    areset();
    step(1'b0);
    check("R8 reset drops pending", cmp_valid_o, 0);
  endtask

  task automatic t_flags();
    goto(0);
    er_set_i = 3'b101; @(negedge clk); er_set_i = '0;
    check("R9 flags set", er_flags_o, 5);
    step(1'b0);
    check("R9 flags hold on step", er_flags_o, 5);
    er_set_i = 3'b010; @(negedge clk); er_set_i = '0;
    check("R9 flags accumulate", er_flags_o, 7);
    card_rst_i = 1'b1; @(negedge clk);
    card_rst_i = 1'b0; er_set_i = 3'b100; @(negedge clk); er_set_i = '0;
    check("R9 clear beats set", er_flags_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_step();
    t_sweep();
    t_pre_field();
    t_reset_clk_high();
    t_coincide();
    t_compare();
    t_flags();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule